// File: doc/BRIEF.md
# Directory Coherence Home Controller

The home controller sits at the node that owns a range of memory blocks and keeps the cached copies of those blocks coherent. It does this without any broadcast medium. For each block it keeps a directory entry made of a state and a presence vector with one bit per processor. Processors send it read-miss, write-miss and write-back requests. The controller answers each one with point-to-point messages. It sends replies carrying data to the requester, invalidations to the sharers recorded in the presence vector, and fetch requests to the single owner of a dirty block.

Requests are taken one at a time, strictly in arrival order. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. The controller then moves through its states:

- ST_IDLE: waiting for a request.
- ST_DECIDE: reads the entry.
- ST_INVAL: sends one invalidation per cycle.
- ST_FETCH: sends the fetch to the owner.
- ST_WAIT: waits for the owner's data on `rsp_valid`/`rsp_data`.
- ST_REPLY: sends the reply and commits the new entry.

The transitions are as follows:

- ST_IDLE goes to ST_DECIDE on acceptance.
- ST_DECIDE goes back to ST_IDLE for a write-back or an unknown kind.
- ST_DECIDE goes to ST_FETCH when the entry is Exclusive.
- ST_DECIDE goes to ST_INVAL when a write finds other sharers.
- ST_DECIDE goes to ST_REPLY in every other case.
- ST_INVAL goes to ST_REPLY after the last sharer.
- ST_FETCH goes to ST_WAIT.
- ST_WAIT goes to ST_REPLY when the response arrives.
- ST_REPLY goes to ST_IDLE.

Top module: `coh_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector, and memory word i holds the value i. `req_ready` is high and `msg_valid` is low.
- R2: A read miss (request kind 0) to an Uncached block produces a reply (message kind 0) to the requester carrying the memory word. The block becomes Shared with only the requester present.
- R3: A read miss to a Shared block replies with the memory word and adds the requester to the presence vector.
- R4: A write miss (request kind 1) to a Shared block sends an invalidation (message kind 1) to every present processor except the requester. Invalidations go one per cycle, lowest ID first, and the reply follows them. A write miss to an Uncached block sends no invalidation. In both cases the block becomes Exclusive with only the requester present.
- R5: A read miss to an Exclusive block sends a fetch (message kind 2) to the owner and waits for the response. It writes the returned word to memory and replies with it. The block becomes Shared with both the old owner and the requester present.
- R6: A write miss to an Exclusive block sends a fetch-and-invalidate (message kind 3) to the owner. It then replies to the requester with the returned word. The block stays Exclusive with only the requester present.
- R7: A write-back (request kind 2) from the owner of an Exclusive block writes its data word to memory and makes the block Uncached with no sharers, and no message is sent. A write-back from any other processor, or to a block that is not Exclusive, changes nothing.
- R8: `req_ready` is low from acceptance until the cycle after the reply, and the controller waits for an owner response however long it takes. Request kind 3 is dropped without a message.
- R9: At all times an Exclusive entry has exactly one presence bit and an Uncached entry has none. Each fetch is sent to that single owner, and each invalidation goes to a processor whose presence bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 unused |
| req_src | input | PW | Requesting processor ID |
| req_addr | input | AW | Block number |
| req_data | input | DW | Write-back data word |
| rsp_valid | input | 1 | Owner's data response is present |
| rsp_data | input | DW | Data word returned by the owner |
| msg_valid | output | 1 | An outgoing message is present this cycle |
| msg_kind | output | 2 | 0 reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dst | output | PW | Destination processor ID |
| msg_addr | output | AW | Block number of the message |
| msg_data | output | DW | Data word (meaningful on replies) |

## Verification
The checks on the directory assume that a processor never issues a read or write miss for a block it already owns Exclusive. They also assume that `rsp_valid` is raised only while a fetch is outstanding. The processor models in the bench respect both rules, since every scripted access comes from a processor that does not hold the block dirty, and the owner model answers only after it has seen its fetch. The bench also confirms by observation that invalidations and fetches match the sharers it expects. Each test builds those sharers up through earlier sequences of reads and writes, so Shared, Exclusive, stale write-back and silent-drop cases all arise from real traffic.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        DS_UNC = 2'd0,
        DS_SHR = 2'd1,
        DS_EXC = 2'd2
    } dstate_e;

    localparam logic [1:0] RQ_READ  = 2'd0;
    localparam logic [1:0] RQ_WRITE = 2'd1;
    localparam logic [1:0] RQ_WBACK = 2'd2;

    typedef enum logic [1:0] {
        MS_REPLY     = 2'd0,
        MS_INVAL     = 2'd1,
        MS_FETCH     = 2'd2,
        MS_FETCH_INV = 2'd3
    } mkind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DECIDE, ST_INVAL, ST_FETCH, ST_WAIT, ST_REPLY
    } fsm_e;
endpackage

// File: rtl/coh_low_pick.sv
module coh_low_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table
    import coh_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    output dstate_e          rd_st,
    output logic [NPROC-1:0] rd_pres,
    input  logic             we,
    input  dstate_e          wr_st,
    input  logic [NPROC-1:0] wr_pres
);
    dstate_e          st_q   [NBLK];
    logic [NPROC-1:0] pres_q [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[b]   <= DS_UNC;
                pres_q[b] <= '0;
            end else if (we && addr == AW'(b)) begin
                st_q[b]   <= wr_st;
                pres_q[b] <= wr_pres;
            end
        end
    end

    assign rd_st   = st_q[addr];
    assign rd_pres = pres_q[addr];
endmodule

// File: rtl/coh_blk_store.sv
module coh_blk_store #(
    parameter int NBLK = 16,
    parameter int AW   = 4,
    parameter int DW   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] word_q [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      word_q[b] <= DW'(b);
            else if (we && addr == AW'(b))   word_q[b] <= wdata;
        end
    end

    assign rdata = word_q[addr];
endmodule

// File: rtl/coh_home_ctrl.sv
module coh_home_ctrl
    import coh_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 16,
    parameter int DW    = 16,
    localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [PW-1:0] req_src,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic          msg_valid,
    output logic [1:0]    msg_kind,
    output logic [PW-1:0] msg_dst,
    output logic [AW-1:0] msg_addr,
    output logic [DW-1:0] msg_data
);
    localparam logic [NPROC-1:0] ONE = NPROC'(1);

    fsm_e             st, st_nx;
    logic [1:0]       r_kind;
    logic [PW-1:0]    r_src;
    logic [AW-1:0]    r_addr;
    logic [DW-1:0]    r_data;
    logic [NPROC-1:0] inv_left;
    logic [NPROC-1:0] src_bit;

    dstate_e          cur_st;
    logic [NPROC-1:0] cur_pres;
    logic             dir_we;
    dstate_e          dir_wst;
    logic [NPROC-1:0] dir_wpres;
    logic [DW-1:0]    mem_q;
    logic             mem_we;
    logic [DW-1:0]    mem_wd;
    logic [PW-1:0]    own_idx;
    logic [PW-1:0]    inv_idx;
    mkind_e           mk;

    assign src_bit = ONE << r_src;

    coh_dir_table #(.NPROC(NPROC), .NBLK(NBLK), .AW(AW)) u_dir (
        .clk(clk), .rst_n(rst_n), .addr(r_addr),
        .rd_st(cur_st), .rd_pres(cur_pres),
        .we(dir_we), .wr_st(dir_wst), .wr_pres(dir_wpres)
    );

    coh_blk_store #(.NBLK(NBLK), .AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n), .addr(r_addr),
        .rdata(mem_q), .we(mem_we), .wdata(mem_wd)
    );

    coh_low_pick #(.N(NPROC), .IW(PW)) u_own (.vec(cur_pres), .idx(own_idx));
    coh_low_pick #(.N(NPROC), .IW(PW)) u_inv (.vec(inv_left), .idx(inv_idx));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (req_valid) st_nx = ST_DECIDE;
            ST_DECIDE: begin
                if (r_kind == RQ_READ || r_kind == RQ_WRITE) begin
                    if (cur_st == DS_EXC)
                        st_nx = ST_FETCH;
                    else if (r_kind == RQ_WRITE && cur_st == DS_SHR &&
                             (cur_pres & ~src_bit) != '0)
                        st_nx = ST_INVAL;
                    else
                        st_nx = ST_REPLY;
                end else begin
                    st_nx = ST_IDLE;
                end
            end
            ST_INVAL:  if ((inv_left & (inv_left - ONE)) == '0) st_nx = ST_REPLY;
            ST_FETCH:  st_nx = ST_WAIT;
            ST_WAIT:   if (rsp_valid) st_nx = ST_REPLY;
            ST_REPLY:  st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // latched request and pending invalidations
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_kind   <= '0;
            r_src    <= '0;
            r_addr   <= '0;
            r_data   <= '0;
            inv_left <= '0;
        end else begin
            if (st == ST_IDLE && req_valid) begin
                r_kind <= req_kind;
                r_src  <= req_src;
                r_addr <= req_addr;
                r_data <= req_data;
            end
            if (st == ST_DECIDE) inv_left <= cur_pres & ~src_bit;
            else if (st == ST_INVAL) inv_left <= inv_left & ~(ONE << inv_idx);
        end
    end

    // outputs and directory / memory updates
    always_comb begin
        req_ready = 1'b0;
        msg_valid = 1'b0;
        mk        = MS_REPLY;
        msg_dst   = r_src;
        mem_we    = 1'b0;
        mem_wd    = r_data;
        dir_we    = 1'b0;
        dir_wst   = cur_st;
        dir_wpres = cur_pres;
        unique case (st)
            ST_IDLE:   req_ready = 1'b1;
            ST_DECIDE: begin
                if (r_kind == RQ_WBACK && cur_st == DS_EXC && cur_pres == src_bit) begin
                    mem_we    = 1'b1;
                    dir_we    = 1'b1;
                    dir_wst   = DS_UNC;
                    dir_wpres = '0;
                end
            end
            ST_INVAL: begin
                msg_valid = 1'b1;
                mk        = MS_INVAL;
                msg_dst   = inv_idx;
            end
            ST_FETCH: begin
                msg_valid = 1'b1;
                mk        = (r_kind == RQ_WRITE) ? MS_FETCH_INV : MS_FETCH;
                msg_dst   = own_idx;
            end
            ST_WAIT: begin
                mem_we = rsp_valid;
                mem_wd = rsp_data;
            end
            ST_REPLY: begin
                msg_valid = 1'b1;
                dir_we    = 1'b1;
                if (r_kind == RQ_READ) begin
                    dir_wst   = DS_SHR;
                    dir_wpres = cur_pres | src_bit;
                end else begin
                    dir_wst   = DS_EXC;
                    dir_wpres = src_bit;
                end
            end
            default: ;
        endcase
    end

    assign msg_kind = mk;
    assign msg_addr = r_addr;
    assign msg_data = mem_q;
endmodule

// File: rtl/coh_home_chk.sv
module coh_home_chk #(
    parameter int NPROC = 4,
    parameter int PW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             msg_valid,
    input logic [1:0]       msg_kind,
    input logic [PW-1:0]    msg_dst,
    input logic [1:0]       cur_st,
    input logic [NPROC-1:0] cur_pres,
    input logic [PW-1:0]    r_src
);
    // R9
    excl_one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == 2'd2) |-> ($countones(cur_pres) == 1));

    // R9
    unc_no_sharer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == 2'd0) |-> (cur_pres == '0));

    // R4
    inval_to_sharer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd1) |->
            (cur_st == 2'd1 && cur_pres[msg_dst] && msg_dst != r_src));

    // R5
    fetch_to_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind[1]) |-> (cur_st == 2'd2 && cur_pres[msg_dst]));

    // R8
    reply_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd0) |=> req_ready);

    // R8
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !msg_valid);
endmodule

bind coh_home_ctrl coh_home_chk #(.NPROC(NPROC), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
    .cur_st(cur_st), .cur_pres(cur_pres), .r_src(r_src)
);

// File: tb/tb_coh_home_ctrl.sv
`timescale 1ns/100ps
module tb_coh_home_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_src = '0;
    logic [3:0]  req_addr = '0;
    logic [15:0] req_data = '0;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_data = '0;
    logic        msg_valid;
    logic [1:0]  msg_kind;
    logic [1:0]  msg_dst;
    logic [3:0]  msg_addr;
    logic [15:0] msg_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    coh_home_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .msg_valid(msg_valid),
        .msg_kind(msg_kind), .msg_dst(msg_dst), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    typedef struct packed {
        logic [1:0]  typ;
        logic [1:0]  src;
        logic [3:0]  addr;
        logic [15:0] data;
        logic [3:0]  inv;
        logic        fe;
        logic [1:0]  fdst;
        logic        rep;
        logic [15:0] rdata;
        logic [3:0]  tag;
        logic [7:0]  dly;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        {2'd0,2'd0,4'd3,16'h0000,4'b0000,1'b0,2'd0,1'b1,16'h0003,4'd2,8'd1},
        {2'd0,2'd1,4'd3,16'h0000,4'b0000,1'b0,2'd0,1'b1,16'h0003,4'd3,8'd1},
        {2'd1,2'd2,4'd3,16'h0000,4'b0011,1'b0,2'd0,1'b1,16'h0003,4'd4,8'd1},
        {2'd0,2'd0,4'd3,16'h00AA,4'b0000,1'b1,2'd2,1'b1,16'h00AA,4'd5,8'd1},
        {2'd1,2'd0,4'd3,16'h0000,4'b0100,1'b0,2'd0,1'b1,16'h00AA,4'd4,8'd1},
        {2'd1,2'd1,4'd3,16'h00BB,4'b0000,1'b1,2'd0,1'b1,16'h00BB,4'd6,8'd1},
        {2'd2,2'd2,4'd3,16'h00CC,4'b0000,1'b0,2'd0,1'b0,16'h0000,4'd7,8'd1},
        {2'd2,2'd1,4'd3,16'h00DD,4'b0000,1'b0,2'd0,1'b0,16'h0000,4'd7,8'd1},
        {2'd0,2'd3,4'd3,16'h0000,4'b0000,1'b0,2'd0,1'b1,16'h00DD,4'd7,8'd1},
        {2'd1,2'd3,4'd3,16'h0000,4'b0000,1'b0,2'd0,1'b1,16'h00DD,4'd4,8'd1},
        {2'd1,2'd2,4'd5,16'h0000,4'b0000,1'b0,2'd0,1'b1,16'h0005,4'd4,8'd1},
        {2'd0,2'd1,4'd5,16'h0055,4'b0000,1'b1,2'd2,1'b1,16'h0055,4'd5,8'd1},
        {2'd3,2'd0,4'd5,16'h0000,4'b0000,1'b0,2'd0,1'b0,16'h0000,4'd8,8'd1},
        {2'd1,2'd0,4'd5,16'h0000,4'b0110,1'b0,2'd0,1'b1,16'h0055,4'd4,8'd1},
        {2'd0,2'd3,4'd15,16'h0000,4'b0000,1'b0,2'd0,1'b1,16'h000F,4'd1,8'd1},
        {2'd2,2'd0,4'd15,16'h1234,4'b0000,1'b0,2'd0,1'b0,16'h0000,4'd7,8'd1},
        {2'd0,2'd2,4'd15,16'h0000,4'b0000,1'b0,2'd0,1'b1,16'h000F,4'd7,8'd1},
        {2'd1,2'd1,4'd5,16'h0777,4'b0000,1'b1,2'd0,1'b1,16'h0777,4'd6,8'd20},
        {2'd2,2'd1,4'd5,16'h0999,4'b0000,1'b0,2'd0,1'b0,16'h0000,4'd7,8'd1},
        {2'd0,2'd2,4'd5,16'h0000,4'b0000,1'b0,2'd0,1'b1,16'h0999,4'd7,8'd1}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input vec_t v);
        logic [3:0]  inv_seen = '0;
        int          fcnt = 0;
        logic [1:0]  fdst = '0;
        logic [1:0]  fkind = '0;
        bit          rep_seen = 0;
        bit          busy_bad = 0;
        bit          done = 0;
        logic [15:0] rdata = '0;
        logic [1:0]  rdst = '0;
        int          pend = 0;
        string       t = tag_name(v.tag);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = v.typ;
        req_src   = v.src;
        req_addr  = v.addr;
        req_data  = v.data;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 80 && !done; c++) begin
            if (msg_valid) begin
                case (msg_kind)
                    2'd0: begin rep_seen = 1; rdata = msg_data; rdst = msg_dst; done = 1; end
                    2'd1: inv_seen[msg_dst] = 1'b1;
                    default: begin fcnt++; fdst = msg_dst; fkind = msg_kind; pend = int'(v.dly); end
                endcase
            end else if (req_ready) begin
                done = 1;
            end
            if (req_ready && !rep_seen && v.rep) busy_bad = 1;
            rsp_valid = 1'b0;
            if (pend > 0 && !(msg_valid && msg_kind[1])) begin
                pend--;
                if (pend == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = v.data;
                end
            end
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        // R4: invalidation targets
        chk(inv_seen == v.inv, "R4", "invalidate set", 32'(inv_seen), 32'(v.inv));
        // R9: single fetch target
        chk(fcnt == int'(v.fe), "R9", "fetch count", 32'(fcnt), 32'(v.fe));
        if (v.fe) begin
            chk(fdst == v.fdst, t, "fetch destination", 32'(fdst), 32'(v.fdst));
            chk(fkind == ((v.typ == 2'd1) ? 2'd3 : 2'd2), t, "fetch kind",
                32'(fkind), (v.typ == 2'd1) ? 32'd3 : 32'd2);
        end
        chk(rep_seen == v.rep, t, "reply presence", 32'(rep_seen), 32'(v.rep));
        if (v.rep) begin
            chk(rdata == v.rdata, t, "reply data", 32'(rdata), 32'(v.rdata));
            chk(rdst == v.src, t, "reply destination", 32'(rdst), 32'(v.src));
            // R8: ready again the cycle after the reply, never before
            chk(req_ready && !busy_bad, "R8", "ready after reply only",
                32'({busy_bad, req_ready}), 32'b01);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        chk(msg_valid == 1'b0, "R1", "no message after reset", 32'(msg_valid), 32'd0);
        for (int i = 0; i < NV; i++) run_txn(VECS[i]);
        // R1: reset restores memory and directory
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn('{typ:2'd0, src:2'd1, addr:4'd3, data:16'h0, inv:4'b0, fe:1'b0,
                  fdst:2'd0, rep:1'b1, rdata:16'h0003, tag:4'd1, dly:8'd1});
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule